// File: doc/BRIEF.md
# Three-Channel Sequence Quality Tester

This block grades raw entropy by streaming statistics. Each accepted sample carries several independent random bit channels in its lowest bits. For every channel, the block cuts the stream into fixed-length sequences. It applies two tests to each sequence: a balance test on a running plus/minus sum, and a runs test that counts transitions and compares the count with a window chosen by the sequence's ones count. No erfc arithmetic is involved: the balance limit is a constant, and the runs window comes from a small bound table that is written before a run.

After a fixed number of sequences, each channel's flag shows whether enough of its sequences passed both tests. A single-cycle pulse marks the end of the evaluation. A start input clears all state and opens a new evaluation. Strobes that arrive while no evaluation is open are dropped. A supervising controller uses the flags to keep or reject an entropy-source configuration.

Top module: `bitchan_quality_tester`

## Requirements
- R1: After reset, `done` is 0, every bit of `ch_pass` is 0, and no evaluation is open.
- R2: Channel c is fed only by bit c of `smp_data` (c = 0, 1, 2). Bits 3 to 11 have no effect on any result.
- R3: The balance test of a 256-bit sequence passes only when the sum of +1 per one bit and -1 per zero bit ends strictly between -41 and +41. With 256 bits, this means a ones count from 108 to 148 inclusive.
- R4: The run count of a sequence is the number of adjacent bit pairs inside that sequence that differ, plus one. A change between the last bit of one sequence and the first bit of the next is not counted.
- R5: The runs test passes when lo[k] <= run count <= hi[k], where k (0 to 256) is the sequence's ones count. Entry k of the table is written with `tbl_lo`/`tbl_hi` on a clock edge where `tbl_we` is 1 and `tbl_addr` = k.
- R6: A channel's flag is 1 only if at least 123 of its 128 sequences passed both tests. A sequence that fails either test does not count.
- R7: `done` is high for exactly one cycle: the cycle after the edge that accepts the 32768th sample of an evaluation. `ch_pass` takes its new value at that same edge and holds it until the next `start`.
- R8: A sample is accepted only on an edge where `smp_vld` is 1 and an evaluation is open. Strobes while idle, and cycles with `smp_vld` at 0, change nothing.
- R9: `start` clears the flags and restarts counting from the first sample of the first sequence, even in the middle of an evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Clear all state and open a new evaluation |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | 12 | Sample; the low three bits are the channels |
| tbl_we | input | 1 | Bound table write enable |
| tbl_addr | input | 9 | Bound table entry (ones count 0 to 256) |
| tbl_lo | input | 9 | Lowest passing run count for the entry |
| tbl_hi | input | 9 | Highest passing run count for the entry |
| ch_pass | output | 3 | Per-channel pass flags |
| done | output | 1 | One-cycle end-of-evaluation pulse |

## Verification
Only two things are visible at the ports: the verdict bits and the end pulse. A corrupted sequence position or sequence count therefore shows up only as `done` arriving at the wrong sample. A corrupted sum, ones count or transition count changes a per-sequence verdict, and that becomes visible only at the end of the evaluation, when a flag differs from its expected value. The stimuli place channels exactly on the tally threshold (123 versus 122 passes) and exactly on the run-window edge (128 versus 129 runs). As a result, a single miscounted sequence or a single extra transition flips a flag within one 32768-sample evaluation.

// File: rtl/bq_pkg.sv
package bq_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } run_state_t;

   typedef struct packed {
      logic mono_ok;
      logic runs_ok;
   } seq_verdict_t;
endpackage

// File: rtl/bq_seq_ctl.sv
module bq_seq_ctl #(
   parameter int SEQ_BITS  = 256,
   parameter int SEQ_COUNT = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic smp_vld,
   output logic take,
   output logic first_bit,
   output logic last_bit,
   output logic last_seq,
   output logic done
);
   import bq_pkg::*;
   localparam int POS_W = $clog2(SEQ_BITS);
   localparam int SEQ_W = $clog2(SEQ_COUNT);

   run_state_t       state_q;
   logic [POS_W-1:0] pos_q;
   logic [SEQ_W-1:0] seq_q;
   logic             done_q;

   assign take      = smp_vld && (state_q == ST_RUN) && !start;
   assign first_bit = (pos_q == '0);
   assign last_bit  = (pos_q == POS_W'(SEQ_BITS - 1));
   assign last_seq  = (seq_q == SEQ_W'(SEQ_COUNT - 1));
   assign done      = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pos_q   <= '0;
         seq_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start) begin
            state_q <= ST_RUN;
            pos_q   <= '0;
            seq_q   <= '0;
         end else if (take) begin
            if (last_bit) begin
               pos_q <= '0;
               if (last_seq) begin
                  seq_q   <= '0;
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  seq_q <= seq_q + 1'b1;
               end
            end else begin
               pos_q <= pos_q + 1'b1;
            end
         end
      end
   end

   // R7: the end pulse lasts one cycle
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   // R7: the evaluation is closed while the pulse is high
   p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (state_q == ST_IDLE));
   // R8: an idle block does not advance on strobes
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_IDLE) && !start) |=> ($stable(pos_q) && $stable(seq_q)));
   // R9: start always returns to the first sample
   p_start_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> ((pos_q == '0) && (seq_q == '0) && (state_q == ST_RUN)));
endmodule

// File: rtl/bq_bound_table.sv
module bq_bound_table #(
   parameter int DEPTH  = 257,
   parameter int VAL_W  = 9,
   parameter int ADDR_W = 9,
   parameter int NUM_RD = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [ADDR_W-1:0]              wr_addr,
   input  logic [VAL_W-1:0]               wr_lo,
   input  logic [VAL_W-1:0]               wr_hi,
   input  logic [NUM_RD-1:0][ADDR_W-1:0]  rd_addr,
   output logic [NUM_RD-1:0][VAL_W-1:0]   rd_lo,
   output logic [NUM_RD-1:0][VAL_W-1:0]   rd_hi
);
   logic [VAL_W-1:0] lo_mem [DEPTH];
   logic [VAL_W-1:0] hi_mem [DEPTH];
   logic             wr_ok;

   assign wr_ok = wr_en && (wr_addr < ADDR_W'(DEPTH));

   always_ff @(posedge clk) begin
      if (wr_ok) begin
         lo_mem[wr_addr] <= wr_lo;
         hi_mem[wr_addr] <= wr_hi;
      end
   end

   for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
      assign rd_lo[r] = (rd_addr[r] < ADDR_W'(DEPTH)) ? lo_mem[rd_addr[r]] : '0;
      assign rd_hi[r] = (rd_addr[r] < ADDR_W'(DEPTH)) ? hi_mem[rd_addr[r]] : '0;
   end

   // R5: a written entry reads back on the next cycle
   p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok |=> ((lo_mem[$past(wr_addr)] == $past(wr_lo)) &&
                 (hi_mem[$past(wr_addr)] == $past(wr_hi))));
endmodule

// File: rtl/bq_chan_eval.sv
module bq_chan_eval #(
   parameter int SEQ_BITS  = 256,
   parameter int SEQ_COUNT = 128,
   parameter int MIN_PASS  = 123,
   parameter int SUM_LIM   = 41
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           clear,
   input  logic                           take,
   input  logic                           first_bit,
   input  logic                           last_bit,
   input  logic                           last_seq,
   input  logic                           bit_in,
   output logic [$clog2(SEQ_BITS+1)-1:0]  k_final,
   input  logic [$clog2(SEQ_BITS+1)-1:0]  run_lo,
   input  logic [$clog2(SEQ_BITS+1)-1:0]  run_hi,
   output logic                           pass_flag
);
   import bq_pkg::*;
   localparam int K_W     = $clog2(SEQ_BITS + 1);
   localparam int SUM_W   = K_W + 1;
   localparam int TALLY_W = $clog2(SEQ_COUNT + 1);
   localparam logic signed [SUM_W-1:0] LIM_HI = SUM_W'(SUM_LIM);
   localparam logic signed [SUM_W-1:0] LIM_LO = -LIM_HI;
   localparam logic signed [SUM_W-1:0] STEP   = SUM_W'(1);

   logic signed [SUM_W-1:0] sum_q, sum_nx;
   logic [K_W-1:0]          ones_q, ones_nx, trans_q, trans_nx, runs_cnt;
   logic                    prev_q, trans_inc, seq_ok, flag_q;
   logic [TALLY_W-1:0]      tally_q, tally_nx;
   seq_verdict_t            verdict;

   always_comb begin
      sum_nx    = sum_q + (bit_in ? STEP : -STEP);
      ones_nx   = ones_q + {{(K_W-1){1'b0}}, bit_in};
      trans_inc = !first_bit && (bit_in != prev_q);
      trans_nx  = trans_q + {{(K_W-1){1'b0}}, trans_inc};
      runs_cnt  = trans_nx + 1'b1;
      verdict.mono_ok = (sum_nx > LIM_LO) && (sum_nx < LIM_HI);
      verdict.runs_ok = (runs_cnt >= run_lo) && (runs_cnt <= run_hi);
      seq_ok    = verdict.mono_ok && verdict.runs_ok;
      tally_nx  = tally_q + {{(TALLY_W-1){1'b0}}, seq_ok};
   end

   assign k_final   = ones_nx;
   assign pass_flag = flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q   <= '0;
         ones_q  <= '0;
         trans_q <= '0;
         prev_q  <= 1'b0;
         tally_q <= '0;
         flag_q  <= 1'b0;
      end else if (clear) begin
         sum_q   <= '0;
         ones_q  <= '0;
         trans_q <= '0;
         prev_q  <= 1'b0;
         tally_q <= '0;
         flag_q  <= 1'b0;
      end else if (take) begin
         prev_q <= bit_in;
         if (last_bit) begin
            sum_q   <= '0;
            ones_q  <= '0;
            trans_q <= '0;
            tally_q <= tally_nx;
            if (last_seq) flag_q <= (tally_nx >= TALLY_W'(MIN_PASS));
         end else begin
            sum_q   <= sum_nx;
            ones_q  <= ones_nx;
            trans_q <= trans_nx;
         end
      end
   end

   // R3: signed sum verdict agrees with the ones count band
   p_mono_band_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (take && last_bit) |-> (verdict.mono_ok ==
         (((2 * int'(k_final) - SEQ_BITS) > -SUM_LIM) &&
          ((2 * int'(k_final) - SEQ_BITS) <  SUM_LIM))));
   // R4: a fresh sequence starts with no transitions
   p_first_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (take && first_bit && !clear) |=> (trans_q == '0));
   // R6: tally never exceeds the sequence count
   p_tally_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tally_q <= TALLY_W'(SEQ_COUNT));
   // R7: flag only moves on start or the final sample
   p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !(take && last_bit && last_seq)) |=> $stable(flag_q));
endmodule

// File: rtl/bitchan_quality_tester.sv
module bitchan_quality_tester #(
   parameter int SAMPLE_W  = 12,
   parameter int NUM_CH    = 3,
   parameter int SEQ_BITS  = 256,
   parameter int SEQ_COUNT = 128,
   parameter int MIN_PASS  = 123,
   parameter int SUM_LIM   = 41
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              start,
   input  logic                              smp_vld,
   input  logic [SAMPLE_W-1:0]               smp_data,
   input  logic                              tbl_we,
   input  logic [$clog2(SEQ_BITS+1)-1:0]     tbl_addr,
   input  logic [$clog2(SEQ_BITS+1)-1:0]     tbl_lo,
   input  logic [$clog2(SEQ_BITS+1)-1:0]     tbl_hi,
   output logic [NUM_CH-1:0]                 ch_pass,
   output logic                              done
);
   localparam int K_W   = $clog2(SEQ_BITS + 1);
   localparam int DEPTH = SEQ_BITS + 1;

   if (NUM_CH < 1 || NUM_CH > SAMPLE_W) begin : g_bad_ch
      $error("NUM_CH must lie between 1 and SAMPLE_W");
   end
   if (SEQ_BITS < 2 || SEQ_COUNT < 2) begin : g_bad_len
      $error("SEQ_BITS and SEQ_COUNT must be at least 2");
   end
   if (MIN_PASS < 1 || MIN_PASS > SEQ_COUNT) begin : g_bad_pass
      $error("MIN_PASS must lie between 1 and SEQ_COUNT");
   end
   if (SUM_LIM < 1 || SUM_LIM > SEQ_BITS) begin : g_bad_lim
      $error("SUM_LIM must lie between 1 and SEQ_BITS");
   end

   logic take, first_bit, last_bit, last_seq;
   logic [NUM_CH-1:0][K_W-1:0] k_bus, lo_bus, hi_bus;

   bq_seq_ctl #(.SEQ_BITS(SEQ_BITS), .SEQ_COUNT(SEQ_COUNT)) u_ctl (
      .clk(clk), .rst_n(rst_n), .start(start), .smp_vld(smp_vld),
      .take(take), .first_bit(first_bit), .last_bit(last_bit),
      .last_seq(last_seq), .done(done)
   );

   bq_bound_table #(.DEPTH(DEPTH), .VAL_W(K_W), .ADDR_W(K_W), .NUM_RD(NUM_CH)) u_tbl (
      .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .wr_addr(tbl_addr),
      .wr_lo(tbl_lo), .wr_hi(tbl_hi),
      .rd_addr(k_bus), .rd_lo(lo_bus), .rd_hi(hi_bus)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      bq_chan_eval #(
         .SEQ_BITS(SEQ_BITS), .SEQ_COUNT(SEQ_COUNT),
         .MIN_PASS(MIN_PASS), .SUM_LIM(SUM_LIM)
      ) u_eval (
         .clk(clk), .rst_n(rst_n), .clear(start), .take(take),
         .first_bit(first_bit), .last_bit(last_bit), .last_seq(last_seq),
         .bit_in(smp_data[c]), .k_final(k_bus[c]),
         .run_lo(lo_bus[c]), .run_hi(hi_bus[c]), .pass_flag(ch_pass[c])
      );
   end

   if (NUM_CH < SAMPLE_W) begin : g_spare
      logic unused_hi_bits;
      assign unused_hi_bits = ^smp_data[SAMPLE_W-1:NUM_CH];
   end

   // R1: nothing is reported straight out of reset
   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!done && (ch_pass == '0)));
   // R9: start clears every flag
   p_start_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (ch_pass == '0));
endmodule

// File: tb/bitchan_quality_tester_test.sv
module bitchan_quality_tester_test;
   localparam int NRUN = 4;
   localparam int SEQB = 256;
   localparam int NSEQ = 128;

   typedef struct packed {
      logic [1:0] kind;   // 0 block of K ones, 1 pairs 0011, 2 alternating, 3 pairs 0110
      logic [8:0] kval;
      logic [7:0] nbad;   // leading all-ones sequences
   } chan_vec_t;

   typedef struct packed {
      logic            permissive;
      logic            gappy;
      logic [2:0]      exp_flags;
      chan_vec_t [2:0] ch;
   } run_vec_t;

   localparam run_vec_t RUNS [NRUN] = '{
      '{1'b0, 1'b0, 3'b101, '{'{2'd1, 9'd0, 8'd5}, '{2'd2, 9'd0, 8'd0}, '{2'd1, 9'd0, 8'd0}}},
      '{1'b0, 1'b0, 3'b000, '{'{2'd3, 9'd0, 8'd0}, '{2'd0, 9'd128, 8'd0}, '{2'd1, 9'd0, 8'd6}}},
      '{1'b1, 1'b0, 3'b101, '{'{2'd0, 9'd108, 8'd0}, '{2'd0, 9'd149, 8'd0}, '{2'd0, 9'd148, 8'd0}}},
      '{1'b1, 1'b1, 3'b010, '{'{2'd0, 9'd0, 8'd0}, '{2'd1, 9'd0, 8'd5}, '{2'd0, 9'd107, 8'd0}}}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        smp_vld = 1'b0;
   logic [11:0] smp_data = '0;
   logic        tbl_we = 1'b0;
   logic [8:0]  tbl_addr = '0, tbl_lo = '0, tbl_hi = '0;
   logic [2:0]  ch_pass;
   logic        done;

   int   n_chk = 0;
   int   n_fail = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #10 clk = ~clk;

   bitchan_quality_tester uut (
      .clk(clk), .rst_n(rst_n), .start(start), .smp_vld(smp_vld),
      .smp_data(smp_data), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
      .tbl_lo(tbl_lo), .tbl_hi(tbl_hi), .ch_pass(ch_pass), .done(done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic gen_bit(input chan_vec_t v, input int seq, input int pos);
      if (seq < int'(v.nbad)) return 1'b1;
      case (v.kind)
         2'd0:    return pos < int'(v.kval);
         2'd1:    return ((pos >> 1) & 1) != 0;
         2'd2:    return (pos & 1) != 0;
         default: return (((pos + 1) >> 1) & 1) != 0;
      endcase
   endfunction

   function automatic logic [8:0] junk_hi();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      return lfsr[8:0];
   endfunction

   // R5: bound table from the bench's own rule
   task automatic load_table(input bit permissive);
      for (int k = 0; k <= SEQB; k++) begin
         int m;
         @(negedge clk);
         m = (2 * k * (SEQB - k)) / SEQB;
         tbl_we   = 1'b1;
         tbl_addr = 9'(k);
         tbl_lo   = permissive ? 9'd0 : 9'((m > 40) ? m - 40 : 0);
         tbl_hi   = permissive ? 9'd256 : 9'(m);
      end
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   task automatic pulse_start();
      @(negedge clk);
      smp_vld = 1'b0;
      start   = 1'b1;
      @(negedge clk);
      start   = 1'b0;
   endtask

   task automatic junk_strobes(input int n, output bit saw_done);
      saw_done = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (done) saw_done = 1'b1;
         smp_vld  = 1'b1;
         smp_data = 12'hFFF;
      end
      @(negedge clk);
      if (done) saw_done = 1'b1;
      smp_vld = 1'b0;
   endtask

   task automatic run_stream(input int r);
      bit early = 1'b0;
      int idx = 0;
      for (int s = 0; s < NSEQ; s++) begin
         for (int p = 0; p < SEQB; p++) begin
            if (RUNS[r].gappy && idx < 2000) begin
               @(negedge clk);
               if (done) early = 1'b1;
               smp_vld  = 1'b0;
               smp_data = 12'hFFF;
            end
            @(negedge clk);
            if (done) early = 1'b1;
            smp_vld  = 1'b1;
            smp_data = {junk_hi(), gen_bit(RUNS[r].ch[2], s, p),
                        gen_bit(RUNS[r].ch[1], s, p), gen_bit(RUNS[r].ch[0], s, p)};
            idx++;
         end
      end
      @(negedge clk);
      smp_vld = 1'b0;
      chk(!early, "R7 no early done", int'(early), 0);
      chk(done == 1'b1, "R7 done after last sample", int'(done), 1);
      chk(ch_pass == RUNS[r].exp_flags, "R6 R3 R4 R5 flags at end", int'(ch_pass),
          int'(RUNS[r].exp_flags));
      @(negedge clk);
      chk(done == 1'b0, "R7 done one cycle", int'(done), 0);
      chk(ch_pass == RUNS[r].exp_flags, "R7 flags hold", int'(ch_pass),
          int'(RUNS[r].exp_flags));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      bit saw;
      repeat (3) @(negedge clk);
      chk(done == 1'b0, "R1 reset done", int'(done), 0);
      chk(ch_pass == 3'b000, "R1 reset flags", int'(ch_pass), 0);
      rst_n = 1'b1;
      // R8: strobes before any start are dropped
      junk_strobes(20, saw);
      chk(!saw, "R8 idle strobes", int'(saw), 0);
      chk(ch_pass == 3'b000, "R1 flags idle", int'(ch_pass), 0);

      for (int r = 0; r < NRUN; r++) begin
         load_table(RUNS[r].permissive);
         pulse_start();
         chk(ch_pass == 3'b000, "R9 start clears flags", int'(ch_pass), 0);
         if (r == 0) begin
            // R9: a restart in mid-evaluation discards the partial work
            junk_strobes(1000, saw);
            chk(!saw, "R9 partial run no done", int'(saw), 0);
            pulse_start();
         end
         run_stream(r);
         // R8: strobes after the end are dropped
         junk_strobes(10, saw);
         chk(!saw, "R8 strobes after done", int'(saw), 0);
         chk(ch_pass == RUNS[r].exp_flags, "R8 flags unchanged", int'(ch_pass),
             int'(RUNS[r].exp_flags));
      end
      // R2: upper sample bits were random noise in every run above
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule